// File: doc/BRIEF.md
# I2C Transfer Status Flag Unit

This block keeps the four status flags that an I2C controller shows to software: transmit holding register empty, transmit end, receive holding register full, and NACK detected. It also decides when a byte moves between the holding registers and the shift register. It takes bit-level events from the bus engine, which are SCL rising edges tagged with their bit index, the sampled acknowledge, start/stop detection and slave-address match. It also takes register accesses from the CPU: a transmit-data write, a receive-data read, a status read, a status write and a transmit-mode write. From these it produces the flags, a one-cycle strobe that loads the transmit holding register into the shifter, a one-cycle strobe that captures a received byte, and a suspend level.

Software clears a flag by writing 0 to it, and only after a status read has shown that flag at 1. When a NACK is flagged with suspension enabled, the data path freezes. Pending transmit data stays in the holding register, no byte is loaded or captured, and the transmit-empty flag does not rise until software clears the NACK flag.

A bus-phase state machine with three states follows the address stage:
- PH_IDLE: the bus is free.
- PH_ADDR: a start or repeated start has been seen and the address is awaited.
- PH_DATA: the address has matched and data bytes are flowing.

Its transitions are:
- PH_IDLE to PH_ADDR on a start.
- PH_ADDR to PH_DATA on an address match.
- PH_DATA to PH_ADDR on a repeated start.
- Any state to PH_IDLE on a stop. A stop wins over a start in the same cycle.

Each flag is a small two-bit machine made of the flag itself and a clear-armed bit. Reading the status arms the clear for each flag that shows 1. A hardware set or a completed clear disarms it.

Top module: `i2c_stat_flags`

## Requirements
- R1: After rst_n is asserted, or for one cycle of soft_rst, all four flags read 0, tx_mode is 0, and shift_load, rx_capture and suspend are 0.
- R2: A status write with a flag's bit at 0 clears that flag only if the most recent status read returned 1 for it and hardware has not set it since. A written 1 has no effect, and so does a 0 written without such a read. Flag bits: 0 transmit empty, 1 transmit end, 2 receive full, 3 NACK.
- R3: When a hardware set and any clear other than reset hit a flag in the same cycle, the flag ends up 1.
- R4: The NACK flag sets on an acknowledge sample that reports NACK, but only when tx_mode is 1 and cfg_nack_susp is 1. It clears only through R2 or reset, and suspend follows it.
- R5: shift_load is a one-cycle pulse one clock after a byte boundary, which is an SCL rise with scl_bit = 9 or a start detect. It is issued only when tx_mode is 1, transmit empty is 0, NACK is 0 and no NACK is flagged in that same cycle. Transmit empty sets together with it. While NACK is 1, written data stays pending and transmit empty stays 0.
- R6: Transmit empty also sets on a tx_mode write of 1 and on an address match while tx_mode is 1. It clears on a transmit-data write or a tx_mode write of 0.
- R7: Transmit end sets on an SCL rise with scl_bit = 9 while transmit empty is 1. It clears on a transmit-data write or a stop detect.
- R8: While tx_mode is 0 and NACK is 0, an SCL rise with scl_bit = 8 (cfg_rx_on_ninth = 0) or scl_bit = 9 (cfg_rx_on_ninth = 1) gives a one-cycle rx_capture pulse and sets receive full. No other bit index does this. With NACK at 1, no capture happens.
- R9: Receive full sets on an address match while tx_mode is 0, but only in PH_ADDR, meaning a start or repeated start has come since the last address match or stop. It clears on a receive-data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous internal reset of the flag unit |
| cfg_nack_susp | input | 1 | Enables NACK flagging and suspension |
| cfg_rx_on_ninth | input | 1 | Receive capture on bit 9 (1) or bit 8 (0) |
| scl_rise | input | 1 | SCL rising-edge event |
| scl_bit | input | 4 | Bit index 1..9 of that SCL rise |
| ack_valid | input | 1 | Acknowledge sampled this cycle |
| ack_nack | input | 1 | Sampled acknowledge was a NACK |
| start_det | input | 1 | Start or repeated start detected |
| stop_det | input | 1 | Stop detected |
| addr_match | input | 1 | Slave address matched |
| mode_wr | input | 1 | CPU write of the transmit-mode bit |
| mode_wdata | input | 1 | Value written to the transmit-mode bit |
| txd_wr | input | 1 | CPU write to the transmit holding register |
| rxd_rd | input | 1 | CPU read of the receive holding register |
| stat_rd | input | 1 | CPU status read |
| stat_wr | input | 1 | CPU status write |
| stat_wdata | input | 4 | Status write data, one bit per flag |
| tx_mode | output | 1 | Current transmit-mode bit |
| stat_flags | output | 4 | Flags: 0 tx empty, 1 tx end, 2 rx full, 3 NACK |
| shift_load | output | 1 | Load holding register into shifter (pulse) |
| rx_capture | output | 1 | Capture received byte into holding register (pulse) |
| suspend | output | 1 | Data path suspended by NACK |

## Verification
Every result of this block is registered once, so each flag, tx_mode, shift_load and rx_capture reflect the event exactly one clock after the edge that samples it, and suspend moves in that same cycle as a copy of the NACK flag. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next edge. It also reads one more cycle after a strobe to confirm the pulse is gone. Bit-index sweeps over both capture settings and all eight NACK-enable combinations are compared with values worked out arithmetically from the requirements.

// File: rtl/i2csf_pkg.sv
package i2csf_pkg;
    localparam int NFLAG   = 4;
    localparam int FI_TXE  = 0;
    localparam int FI_TEND = 1;
    localparam int FI_RXF  = 2;
    localparam int FI_NACK = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/i2csf_flag_cell.sv
module i2csf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic stat_rd,
    input  logic sw_clr_req,
    output logic flag_o
);
    logic flag_q, flag_d;
    logic armed_q, armed_d;
    logic sw_clr_ok;

    assign sw_clr_ok = sw_clr_req && armed_q;

    // next-state logic
    always_comb begin
        flag_d  = flag_q;
        armed_d = armed_q;
        if (hw_set) begin
            flag_d  = 1'b1;
            armed_d = 1'b0;
        end else begin
            if (hw_clr || sw_clr_ok) flag_d = 1'b0;
            if (sw_clr_ok)           armed_d = 1'b0;
            else if (stat_rd)        armed_d = flag_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (soft_rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            armed_q <= armed_d;
        end
    end

    assign flag_o = flag_q;

    // R1
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !flag_q);
    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set && !soft_rst) |=> flag_q);
    // R2
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !armed_q && !hw_clr && !soft_rst) |=> flag_q);
endmodule

// File: rtl/i2csf_phase_fsm.sv
module i2csf_phase_fsm
    import i2csf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic start_det,
    input  logic stop_det,
    input  logic addr_match,
    output logic addr_phase
);
    phase_e ph_q, ph_d;

    // transitions
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: begin
                if (stop_det)       ph_d = PH_IDLE;
                else if (start_det) ph_d = PH_ADDR;
            end
            PH_ADDR: begin
                if (stop_det)        ph_d = PH_IDLE;
                else if (start_det)  ph_d = PH_ADDR;
                else if (addr_match) ph_d = PH_DATA;
            end
            PH_DATA: begin
                if (stop_det)       ph_d = PH_IDLE;
                else if (start_det) ph_d = PH_ADDR;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ph_q <= PH_IDLE;
        else if (soft_rst) ph_q <= PH_IDLE;
        else               ph_q <= ph_d;
    end

    // outputs
    always_comb begin
        addr_phase = (ph_q == PH_ADDR);
    end

    // R9
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (ph_q == PH_IDLE));
    // R9
    match_leaves_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && addr_match && !start_det) |=> !addr_phase);
endmodule

// File: rtl/i2csf_evt_dec.sv
module i2csf_evt_dec
    import i2csf_pkg::*;
#(
    parameter int BIT_W = 4
) (
    input  logic             cfg_nack_susp,
    input  logic             cfg_rx_on_ninth,
    input  logic             scl_rise,
    input  logic [BIT_W-1:0] scl_bit,
    input  logic             ack_valid,
    input  logic             ack_nack,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             addr_match,
    input  logic             addr_phase,
    input  logic             mode_wr,
    input  logic             mode_wdata,
    input  logic             tx_mode,
    input  logic             txd_wr,
    input  logic             rxd_rd,
    input  logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] set_v,
    output logic [NFLAG-1:0] clr_v,
    output logic             load_go,
    output logic             cap_go
);
    localparam logic [BIT_W-1:0] ACK_EDGE  = BIT_W'(9);
    localparam logic [BIT_W-1:0] BYTE_EDGE = BIT_W'(8);

    logic last_edge, rx_edge, nack_now, boundary;

    always_comb begin
        last_edge = scl_rise && (scl_bit == ACK_EDGE);
        rx_edge   = scl_rise && (scl_bit == (cfg_rx_on_ninth ? ACK_EDGE : BYTE_EDGE));
        nack_now  = ack_valid && ack_nack && tx_mode && cfg_nack_susp;
        boundary  = last_edge || start_det;
        load_go   = boundary && tx_mode && !flags[FI_TXE] && !flags[FI_NACK] && !nack_now;
        cap_go    = rx_edge && !tx_mode && !flags[FI_NACK];

        set_v[FI_TXE]  = load_go || (mode_wr && mode_wdata) || (addr_match && tx_mode);
        clr_v[FI_TXE]  = txd_wr || (mode_wr && !mode_wdata);
        set_v[FI_TEND] = last_edge && flags[FI_TXE];
        clr_v[FI_TEND] = txd_wr || stop_det;
        set_v[FI_RXF]  = cap_go || (addr_match && !tx_mode && addr_phase);
        clr_v[FI_RXF]  = rxd_rd;
        set_v[FI_NACK] = nack_now;
        clr_v[FI_NACK] = 1'b0;
    end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2csf_pkg::*;
#(
    parameter int BIT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cfg_nack_susp,
    input  logic             cfg_rx_on_ninth,
    input  logic             scl_rise,
    input  logic [BIT_W-1:0] scl_bit,
    input  logic             ack_valid,
    input  logic             ack_nack,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             addr_match,
    input  logic             mode_wr,
    input  logic             mode_wdata,
    input  logic             txd_wr,
    input  logic             rxd_rd,
    input  logic             stat_rd,
    input  logic             stat_wr,
    input  logic [NFLAG-1:0] stat_wdata,
    output logic             tx_mode,
    output logic [NFLAG-1:0] stat_flags,
    output logic             shift_load,
    output logic             rx_capture,
    output logic             suspend
);
    logic [NFLAG-1:0] flags_q, set_v, clr_v;
    logic load_go, cap_go, addr_phase;
    logic mode_q, load_q, cap_q;

    i2csf_phase_fsm u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_match (addr_match),
        .addr_phase (addr_phase)
    );

    i2csf_evt_dec #(.BIT_W(BIT_W)) u_dec (
        .cfg_nack_susp   (cfg_nack_susp),
        .cfg_rx_on_ninth (cfg_rx_on_ninth),
        .scl_rise        (scl_rise),
        .scl_bit         (scl_bit),
        .ack_valid       (ack_valid),
        .ack_nack        (ack_nack),
        .start_det       (start_det),
        .stop_det        (stop_det),
        .addr_match      (addr_match),
        .addr_phase      (addr_phase),
        .mode_wr         (mode_wr),
        .mode_wdata      (mode_wdata),
        .tx_mode         (mode_q),
        .txd_wr          (txd_wr),
        .rxd_rd          (rxd_rd),
        .flags           (flags_q),
        .set_v           (set_v),
        .clr_v           (clr_v),
        .load_go         (load_go),
        .cap_go          (cap_go)
    );

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        i2csf_flag_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst   (soft_rst),
            .hw_set     (set_v[k]),
            .hw_clr     (clr_v[k]),
            .stat_rd    (stat_rd),
            .sw_clr_req (stat_wr && !stat_wdata[k]),
            .flag_o     (flags_q[k])
        );
    end

    // mode bit and strobe registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            load_q <= 1'b0;
            cap_q  <= 1'b0;
        end else if (soft_rst) begin
            mode_q <= 1'b0;
            load_q <= 1'b0;
            cap_q  <= 1'b0;
        end else begin
            if (mode_wr) mode_q <= mode_wdata;
            load_q <= load_go;
            cap_q  <= cap_go;
        end
    end

    // outputs
    always_comb begin
        tx_mode    = mode_q;
        stat_flags = flags_q;
        shift_load = load_q;
        rx_capture = cap_q;
        suspend    = flags_q[FI_NACK];
    end

    // R5
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |=> !shift_load);
    // R5
    load_sets_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |-> stat_flags[FI_TXE]);
    // R4
    susp_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> !shift_load);
    // R8
    cap_sets_rxf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_capture |-> stat_flags[FI_RXF]);
    // R8
    susp_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !soft_rst) |=> !rx_capture);
endmodule

// File: tb/test_i2c_stat_flags.sv
module test_i2c_stat_flags;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, cfg_nack_susp = 0, cfg_rx_on_ninth = 0;
    logic scl_rise = 0, ack_valid = 0, ack_nack = 0;
    logic [3:0] scl_bit = 4'd0;
    logic start_det = 0, stop_det = 0, addr_match = 0;
    logic mode_wr = 0, mode_wdata = 0, txd_wr = 0, rxd_rd = 0;
    logic stat_rd = 0, stat_wr = 0;
    logic [3:0] stat_wdata = 4'd0;
    logic tx_mode, shift_load, rx_capture, suspend;
    logic [3:0] stat_flags;
    int nvec = 0, nbad = 0;

    always #5 clk = ~clk;

    i2c_stat_flags i_i2c_stat_flags (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_nack_susp(cfg_nack_susp), .cfg_rx_on_ninth(cfg_rx_on_ninth),
        .scl_rise(scl_rise), .scl_bit(scl_bit), .ack_valid(ack_valid),
        .ack_nack(ack_nack), .start_det(start_det), .stop_det(stop_det),
        .addr_match(addr_match), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .txd_wr(txd_wr), .rxd_rd(rxd_rd), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .tx_mode(tx_mode), .stat_flags(stat_flags),
        .shift_load(shift_load), .rx_capture(rx_capture), .suspend(suspend)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one edge: pulses set before are sampled, then dropped
    task automatic tick();
        @(posedge clk);
        #1;
        soft_rst = 0; scl_rise = 0; ack_valid = 0; ack_nack = 0;
        start_det = 0; stop_det = 0; addr_match = 0; mode_wr = 0;
        txd_wr = 0; rxd_rd = 0; stat_rd = 0; stat_wr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; cfg_nack_susp = 0; cfg_rx_on_ninth = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic mode(input logic v);
        mode_wr = 1; mode_wdata = v; tick();
    endtask
    task automatic scl(input int b);
        scl_rise = 1; scl_bit = 4'(b); tick();
    endtask
    task automatic nack_ev(input logic n);
        ack_valid = 1; ack_nack = n; tick();
    endtask
    task automatic rd_stat();
        stat_rd = 1; tick();
    endtask
    task automatic wr_stat(input logic [3:0] w);
        stat_wr = 1; stat_wdata = w; tick();
    endtask

    task automatic set_flag(input int f);
        case (f)
            0: mode(1);
            1: begin mode(1); scl(9); end
            2: scl(8);
            default: begin cfg_nack_susp = 1; mode(1); nack_ev(1); end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 flags", stat_flags, 0);
        chk("R1 tx_mode", tx_mode, 0);
        chk("R1 strobes", {shift_load, rx_capture, suspend}, 0);

        // R8 sweep over capture point and bit index
        for (int c = 0; c < 2; c++) begin
            for (int b = 1; b <= 9; b++) begin
                do_reset();
                cfg_rx_on_ninth = c[0];
                scl(b);
                chk("R8 capture", rx_capture, (b == 8 + c) ? 1 : 0);
                chk("R8 rx_full", stat_flags[2], (b == 8 + c) ? 1 : 0);
                tick();
                chk("R8 pulse width", rx_capture, 0);
            end
        end
        // R8 no capture while NACK is set
        do_reset();
        cfg_nack_susp = 1; mode(1); nack_ev(1); mode(0);
        scl(8);
        chk("R8 suspended capture", rx_capture, 0);
        chk("R8 suspended rx_full", stat_flags[2], 0);

        // R4 sweep over enable, mode and ack value
        for (int i = 0; i < 8; i++) begin
            do_reset();
            cfg_nack_susp = i[0];
            if (i[1]) mode(1);
            nack_ev(i[2]);
            chk("R4 nack flag", stat_flags[3], (i == 7) ? 1 : 0);
            chk("R4 suspend", suspend, (i == 7) ? 1 : 0);
        end

        // R6 transmit-empty sets and clears
        do_reset();
        mode(1);
        chk("R6 mode write sets", stat_flags[0], 1);
        chk("R6 tx_mode", tx_mode, 1);
        txd_wr = 1; tick();
        chk("R6 data write clears", stat_flags[0], 0);
        mode(1);
        mode(0);
        chk("R6 mode 0 clears", stat_flags[0], 0);
        mode(1); txd_wr = 1; tick();
        addr_match = 1; tick();
        chk("R6 tx address match sets", stat_flags[0], 1);

        // R5 / R7 load and transmit end
        do_reset();
        cfg_nack_susp = 1;
        mode(1);
        scl(9);
        chk("R7 tend set", stat_flags[1], 1);
        chk("R5 no load when empty", shift_load, 0);
        txd_wr = 1; tick();
        chk("R7 data write clears tend", stat_flags[1], 0);
        chk("R6 data write clears", stat_flags[0], 0);
        scl(9);
        chk("R5 load on bit 9", shift_load, 1);
        chk("R5 load sets empty", stat_flags[0], 1);
        chk("R7 no tend when loading", stat_flags[1], 0);
        tick();
        chk("R5 load pulse width", shift_load, 0);
        scl(9);
        chk("R7 tend again", stat_flags[1], 1);
        stop_det = 1; tick();
        chk("R7 stop clears tend", stat_flags[1], 0);
        txd_wr = 1; tick();
        start_det = 1; tick();
        chk("R5 load on start", shift_load, 1);
        txd_wr = 1; tick();
        scl_rise = 1; scl_bit = 4'd9; ack_valid = 1; ack_nack = 1; tick();
        chk("R5 nack same cycle blocks load", shift_load, 0);
        chk("R5 empty stays 0", stat_flags[0], 0);
        chk("R4 nack set", suspend, 1);
        txd_wr = 1; tick();
        chk("R5 write while suspended", stat_flags[0], 0);
        scl(9);
        chk("R5 held while suspended", shift_load, 0);
        chk("R5 empty held 0", stat_flags[0], 0);
        rd_stat();
        wr_stat(4'b0111);
        chk("R2 nack cleared", stat_flags[3], 0);
        chk("R4 suspend released", suspend, 0);
        chk("R2 ones ignored", stat_flags[0], 0);
        scl(9);
        chk("R5 load after release", shift_load, 1);

        // R2 read-then-write-0 per flag
        for (int f = 0; f < 4; f++) begin
            do_reset();
            set_flag(f);
            wr_stat(4'h0);
            chk("R2 unread write 0", stat_flags[f], 1);
            rd_stat();
            wr_stat(4'hF);
            chk("R2 write 1", stat_flags[f], 1);
            wr_stat(4'h0);
            chk("R2 armed clear", stat_flags[f], 0);
        end
        // R2 hardware set disarms
        do_reset();
        scl(8); rd_stat(); scl(8);
        wr_stat(4'h0);
        chk("R2 rearm after hw set", stat_flags[2], 1);

        // R3 set beats clear
        do_reset();
        scl_rise = 1; scl_bit = 4'd8; rxd_rd = 1; tick();
        chk("R3 capture vs read", stat_flags[2], 1);
        do_reset();
        mode(1);
        scl_rise = 1; scl_bit = 4'd9; txd_wr = 1; tick();
        chk("R3 tend vs data write", stat_flags[1], 1);
        chk("R6 empty cleared", stat_flags[0], 0);
        do_reset();
        scl(8); rd_stat();
        scl_rise = 1; scl_bit = 4'd8; stat_wr = 1; stat_wdata = 4'h0; tick();
        chk("R3 capture vs armed clear", stat_flags[2], 1);

        // R9 address match in receive mode
        do_reset();
        addr_match = 1; tick();
        chk("R9 no start", stat_flags[2], 0);
        start_det = 1; tick();
        addr_match = 1; tick();
        chk("R9 after start", stat_flags[2], 1);
        rxd_rd = 1; tick();
        chk("R9 read clears", stat_flags[2], 0);
        addr_match = 1; tick();
        chk("R9 data phase", stat_flags[2], 0);
        start_det = 1; tick();
        addr_match = 1; tick();
        chk("R9 repeated start", stat_flags[2], 1);
        rxd_rd = 1; tick();
        start_det = 1; tick();
        stop_det = 1; tick();
        addr_match = 1; tick();
        chk("R9 after stop", stat_flags[2], 0);
        mode(1);
        start_det = 1; tick();
        txd_wr = 1; tick();
        addr_match = 1; tick();
        chk("R9 tx mode no rx_full", stat_flags[2], 0);
        chk("R6 tx match sets empty", stat_flags[0], 1);

        // R1 soft reset
        do_reset();
        cfg_nack_susp = 1; mode(1); scl(9); nack_ev(1);
        chk("R1 flags before soft reset", stat_flags, 4'b1011);
        soft_rst = 1; tick();
        chk("R1 soft reset flags", stat_flags, 0);
        chk("R1 soft reset mode", tx_mode, 0);
        chk("R1 soft reset suspend", suspend, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule